// File: doc/BRIEF.md
# Transmit Holding FIFO with Empty Interrupt

This block sits between a host bus and a serial transmitter. The host writes bytes into a transmit holding register, which is backed by a queue of up to 16 bytes when queue mode is on and by a single byte when it is off. The serializer pulls bytes from the head of the queue with a pop strobe. The block keeps a holding-register-empty flag and decides when that flag may rise. It also keeps a pending transmit-empty interrupt and folds it into an interrupt identification code and a single interrupt request, together with two receive-side pending inputs.

There is a special rule for when the empty flag rises. Suppose a byte is drained and the queue never held two bytes at once since the flag last rose. In that case the flag is held back for one character time minus the final stop bit. The hold-back is counted in baud ticks as `char_len - stop_len`. If the queue did hold two bytes at once in that period, the flag rises immediately. In single-byte mode it always rises immediately. Switching the mode flushes the queue and raises the flag and the interrupt at once.

Top module: `tx_hold_fifo_irq`

## Requirements
- R1: After reset, thr_empty is 1, tx_ready is 0, irq is 0 and iid reads 1h (nothing pending).
- R2: In queue mode (fifo_en=1) up to 16 bytes are held and presented on tx_data oldest first. A write while 16 are held is dropped.
- R3: In single-byte mode (fifo_en=0) one byte is held and a second write is dropped. Draining it raises thr_empty on the same clock edge, with no hold-back.
- R4: thr_empty falls on the edge that accepts a host write. It is 1 only while no byte is held.
- R5: If two or more bytes were held at once since thr_empty last rose, the pop that empties the queue raises thr_empty on that same edge.
- R6: If not, thr_empty rises on the edge of the (char_len - stop_len)-th baud tick after the emptying pop. When char_len <= stop_len it rises at once.
- R7: A host write during a hold-back cancels it. A later emptying pop starts a fresh full-length hold-back.
- R8: Any change of fifo_en flushes the queue, sets thr_empty and sets the pending transmit-empty interrupt on the next edge.
- R9: iid reads 2h only when fifo_en=1, txe_ie=1 and a transmit-empty interrupt is pending. irq is 1 whenever iid differs from 1h.
- R10: A pending transmit-empty interrupt is cleared by a host write, or by an iid_rd strobe while iid reads 2h. An iid_rd while a receive code is shown leaves it pending.
- R11: Receive data pending (code 4h) outranks receive timeout (code Ch), which outranks transmit-empty (2h). 1h means none.
- R12: Each rise of thr_empty clears the two-bytes-held memory, so a later single-byte burst is held back again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1: 16-byte queue mode, 0: single-byte mode |
| txe_ie | input | 1 | Transmit-empty interrupt enable |
| host_wr | input | 1 | Host write strobe into the holding register |
| host_wdata | input | 8 | Host write byte |
| iid_rd | input | 1 | Host read strobe of the interrupt identification |
| tx_pop | input | 1 | Serializer takes the head byte |
| tx_data | output | 8 | Head byte of the queue |
| tx_ready | output | 1 | At least one byte is held |
| baud_tick | input | 1 | Timing tick counting the hold-back |
| char_len | input | 8 | Ticks per character |
| stop_len | input | 8 | Ticks in the final stop bit |
| rx_data_pend | input | 1 | Receive data interrupt pending |
| rx_tmo_pend | input | 1 | Receive timeout interrupt pending |
| thr_empty | output | 1 | Holding register empty flag |
| irq | output | 1 | Interrupt request |
| iid | output | 4 | Interrupt identification code |

## Verification
The assertions check the rules that hold on every cycle. thr_empty never coexists with a held byte, and an accepted write always drops it and stops any hold-back. The queue never exceeds its mode's depth. Single-byte drains are never held back, a host write always clears the pending interrupt, and code 2h only appears with both enables set, behind receive codes. The bench scenarios check the rest: the exact hold-back length in ticks, its restart after a cancelling write, the zero-length case, the two-bytes memory being cleared between bursts, FIFO ordering with an overfill, and the flush on a mode change.

// File: rtl/txe_pkg.sv
package txe_pkg;

    typedef enum logic [3:0] {
        IID_NONE = 4'h1,
        IID_TXE  = 4'h2,
        IID_RXD  = 4'h4,
        IID_RTO  = 4'hC
    } iid_e;

    // Per-cycle queue events handed from storage to the flag logic
    typedef struct packed {
        logic flush;      // mode change: queue cleared
        logic push;       // host byte accepted
        logic pop;        // head byte taken by serializer
        logic drained;    // this edge leaves the queue empty
        logic two_held;   // this edge leaves two or more bytes queued
    } q_evt_t;

    // Hold-back length: character time less final stop bit, floored at 0
    function automatic logic [7:0] gap_ticks(input logic [7:0] chr,
                                             input logic [7:0] stp);
        return (chr > stp) ? (chr - stp) : 8'd0;
    endfunction

endpackage

// File: rtl/txe_queue.sv
module txe_queue
    import txe_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              deep_mode,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  level,
    output q_evt_t            evt
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wp, rp, wp_inc, rp_inc;
    logic [CNT_W-1:0]  cap, level_nxt;
    logic              push, pop;

    assign cap  = deep_mode ? CNT_W'(DEPTH) : CNT_W'(1);
    assign push = wr_req && (level < cap) && !flush;
    assign pop  = rd_req && (level != '0) && !flush;

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wp_inc = wp + 1'b1;
            assign rp_inc = rp + 1'b1;
        end else begin : g_wrap
            assign wp_inc = (wp == LAST) ? '0 : wp + 1'b1;
            assign rp_inc = (rp == LAST) ? '0 : rp + 1'b1;
        end
    endgenerate

    always_comb begin
        level_nxt = level;
        if (flush)
            level_nxt = '0;
        else if (push && !pop)
            level_nxt = level + 1'b1;
        else if (pop && !push)
            level_nxt = level - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            level <= level_nxt;
            if (push) wp <= wp_inc;
            if (pop)  rp <= rp_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (push) store[wp] <= wr_data;
    end

    assign head = store[rp];

    always_comb begin
        evt          = '0;
        evt.flush    = flush;
        evt.push     = push;
        evt.pop      = pop;
        evt.drained  = pop && !push && (level == CNT_W'(1));
        evt.two_held = !flush && (level_nxt >= CNT_W'(2));
    end

endmodule

// File: rtl/txe_holdoff.sv
module txe_holdoff
    import txe_pkg::*;
#(
    parameter int unsigned TIME_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  q_evt_t            evt,
    input  logic              deep_mode,
    input  logic              baud_tick,
    input  logic [TIME_W-1:0] char_len,
    input  logic [TIME_W-1:0] stop_len,
    output logic              empty_flag,
    output logic              rise,
    output logic              waiting
);
    logic [TIME_W-1:0] left, gap;
    logic              pair_seen;
    logic              go_now;

    assign gap    = gap_ticks(char_len, stop_len);
    assign go_now = !deep_mode || pair_seen || (gap == '0);

    // rise: the flag becomes set on this edge
    always_comb begin
        rise = 1'b0;
        if (evt.flush)
            rise = !empty_flag || 1'b1;
        else if (evt.push)
            rise = 1'b0;
        else if (evt.drained)
            rise = go_now;
        else if (waiting && baud_tick && left == TIME_W'(1))
            rise = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_flag <= 1'b1;
            pair_seen  <= 1'b0;
            waiting    <= 1'b0;
            left       <= '0;
        end else if (evt.flush) begin
            empty_flag <= 1'b1;
            pair_seen  <= 1'b0;
            waiting    <= 1'b0;
            left       <= '0;
        end else if (evt.push) begin
            empty_flag <= 1'b0;
            waiting    <= 1'b0;
            if (evt.two_held) pair_seen <= 1'b1;
        end else if (evt.drained) begin
            if (go_now) begin
                empty_flag <= 1'b1;
                pair_seen  <= 1'b0;
            end else begin
                waiting <= 1'b1;
                left    <= gap;
            end
        end else if (waiting && baud_tick) begin
            if (left == TIME_W'(1)) begin
                empty_flag <= 1'b1;
                pair_seen  <= 1'b0;
                waiting    <= 1'b0;
            end else begin
                left <= left - 1'b1;
            end
        end
    end

endmodule

// File: rtl/txe_irq_id.sv
module txe_irq_id
    import txe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rise,
    input  logic       host_wr,
    input  logic       iid_rd,
    input  logic       deep_mode,
    input  logic       txe_ie,
    input  logic       rx_data_pend,
    input  logic       rx_tmo_pend,
    output iid_e       code,
    output logic       req,
    output logic       pending
);
    logic tx_live;

    assign tx_live = deep_mode && txe_ie && pending;

    always_comb begin
        if (rx_data_pend)
            code = IID_RXD;
        else if (rx_tmo_pend)
            code = IID_RTO;
        else if (tx_live)
            code = IID_TXE;
        else
            code = IID_NONE;
    end

    assign req = (code != IID_NONE);

    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else if (rise)
            pending <= 1'b1;
        else if (host_wr)
            pending <= 1'b0;
        else if (iid_rd && code == IID_TXE)
            pending <= 1'b0;
    end

endmodule

// File: rtl/tx_hold_fifo_irq.sv
module tx_hold_fifo_irq
    import txe_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned TIME_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_en,
    input  logic              txe_ie,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              iid_rd,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    input  logic              baud_tick,
    input  logic [TIME_W-1:0] char_len,
    input  logic [TIME_W-1:0] stop_len,
    input  logic              rx_data_pend,
    input  logic              rx_tmo_pend,
    output logic              thr_empty,
    output logic              irq,
    output logic [3:0]        iid
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic             mode_q;
    logic             mode_chg;
    logic [CNT_W-1:0] level;
    q_evt_t           evt;
    logic             rise;
    logic             waiting;
    logic             pending;
    iid_e             code;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= 1'b0;
        else     mode_q <= fifo_en;
    end
    assign mode_chg = (mode_q != fifo_en) && !rst;

    txe_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .flush     (mode_chg),
        .deep_mode (fifo_en),
        .wr_req    (host_wr),
        .wr_data   (host_wdata),
        .rd_req    (tx_pop),
        .head      (tx_data),
        .level     (level),
        .evt       (evt)
    );

    txe_holdoff #(.TIME_W(TIME_W)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .deep_mode  (fifo_en),
        .baud_tick  (baud_tick),
        .char_len   (char_len),
        .stop_len   (stop_len),
        .empty_flag (thr_empty),
        .rise       (rise),
        .waiting    (waiting)
    );

    txe_irq_id u_irq (
        .clk          (clk),
        .rst          (rst),
        .rise         (rise),
        .host_wr      (host_wr),
        .iid_rd       (iid_rd),
        .deep_mode    (fifo_en),
        .txe_ie       (txe_ie),
        .rx_data_pend (rx_data_pend),
        .rx_tmo_pend  (rx_tmo_pend),
        .code         (code),
        .req          (irq),
        .pending      (pending)
    );

    assign iid      = code;
    assign tx_ready = (level != '0);

endmodule

// File: rtl/txe_chk.sv
module txe_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_en,
    input logic             txe_ie,
    input logic             host_wr,
    input logic             mode_chg,
    input logic             push,
    input logic             drained,
    input logic [CNT_W-1:0] level,
    input logic             thr_empty,
    input logic             waiting,
    input logic             pending,
    input logic             rx_data_pend,
    input logic             rx_tmo_pend,
    input logic [3:0]       iid
);
    // R4: flag only while nothing is held
    a_r4_flag_means_drained: assert property (@(posedge clk) disable iff (rst)
        thr_empty |-> (level == '0));

    // R4, R7: accepted write drops the flag and ends any hold-back
    a_r4_write_drops_flag: assert property (@(posedge clk) disable iff (rst)
        (push && !mode_chg) |=> (!thr_empty && !waiting));

    // R2: never above the queue depth
    a_r2_depth_bound: assert property (@(posedge clk) disable iff (rst)
        level <= CNT_W'(DEPTH));

    // R3: single-byte mode holds at most one byte and never holds back
    a_r3_single_bound: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && !mode_chg) |-> (level <= CNT_W'(1)));
    a_r3_no_holdback: assert property (@(posedge clk) disable iff (rst)
        (drained && !fifo_en && !mode_chg) |=> thr_empty);

    // R8: mode change leaves an empty, flagged, pending state
    a_r8_flush_raises: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> (thr_empty && pending && level == '0));

    // R9: transmit code needs both enables
    a_r9_code_gated: assert property (@(posedge clk) disable iff (rst)
        (iid == 4'h2) |-> (fifo_en && txe_ie && pending));

    // R10: host write clears the pending interrupt
    a_r10_write_clears: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !mode_chg) |=> !pending);

    // R11: receive codes win
    a_r11_rx_data_first: assert property (@(posedge clk) disable iff (rst)
        rx_data_pend |-> (iid == 4'h4));
    a_r11_rx_tmo_next: assert property (@(posedge clk) disable iff (rst)
        (rx_tmo_pend && !rx_data_pend) |-> (iid == 4'hC));
endmodule

bind tx_hold_fifo_irq txe_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_txe_chk (
    .clk          (clk),
    .rst          (rst),
    .fifo_en      (fifo_en),
    .txe_ie       (txe_ie),
    .host_wr      (host_wr),
    .mode_chg     (mode_chg),
    .push         (evt.push),
    .drained      (evt.drained),
    .level        (level),
    .thr_empty    (thr_empty),
    .waiting      (waiting),
    .pending      (pending),
    .rx_data_pend (rx_data_pend),
    .rx_tmo_pend  (rx_tmo_pend),
    .iid          (iid)
);

// File: tb/test_tx_hold_fifo_irq.sv
module test_tx_hold_fifo_irq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en = 1'b0, txe_ie = 1'b0;
    logic       host_wr = 1'b0, iid_rd = 1'b0, tx_pop = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       baud_tick = 1'b0;
    logic [7:0] char_len = 8'd10, stop_len = 8'd1;
    logic       rx_data_pend = 1'b0, rx_tmo_pend = 1'b0;
    logic [7:0] tx_data;
    logic       tx_ready, thr_empty, irq;
    logic [3:0] iid;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    tx_hold_fifo_irq i_tx_hold_fifo_irq (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .txe_ie(txe_ie),
        .host_wr(host_wr), .host_wdata(host_wdata), .iid_rd(iid_rd),
        .tx_pop(tx_pop), .tx_data(tx_data), .tx_ready(tx_ready),
        .baud_tick(baud_tick), .char_len(char_len), .stop_len(stop_len),
        .rx_data_pend(rx_data_pend), .rx_tmo_pend(rx_tmo_pend),
        .thr_empty(thr_empty), .irq(irq), .iid(iid)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        host_wr = 1'b1; host_wdata = b; tick(); host_wr = 1'b0;
    endtask

    task automatic take();
        tx_pop = 1'b1; tick(); tx_pop = 1'b0;
    endtask

    task automatic ticks(input int n);
        baud_tick = 1'b1; repeat (n) tick(); baud_tick = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1 thr_empty", thr_empty, 1);
        chk("R1 tx_ready", tx_ready, 0);
        chk("R1 irq", irq, 0);
        chk("R1 iid", iid, 4'h1);
    endtask

    task automatic t_enable();
        fifo_en = 1'b1; txe_ie = 1'b1;
        tick();
        chk("R8 flag after enable", thr_empty, 1);
        chk("R9 iid after enable", iid, 4'h2);
        chk("R9 irq after enable", irq, 1);
        iid_rd = 1'b1; tick(); iid_rd = 1'b0;
        chk("R10 iid read clears", iid, 4'h1);
    endtask

    task automatic t_pair_immediate();
        put(8'h11);
        chk("R4 write drops flag", thr_empty, 0);
        put(8'h22);
        chk("R2 head oldest", tx_data, 8'h11);
        take();
        chk("R2 next head", tx_data, 8'h22);
        chk("R5 flag low with one left", thr_empty, 0);
        take();
        chk("R5 immediate after pair", thr_empty, 1);
        chk("R9 code after drain", iid, 4'h2);
    endtask

    task automatic t_single_delay();
        put(8'h33);
        chk("R10 write clears pending", iid, 4'h1);
        take();
        chk("R12 single byte held back", thr_empty, 0);
        ticks(8);
        chk("R6 still held at gap-1", thr_empty, 0);
        ticks(1);
        chk("R6 rises at gap", thr_empty, 1);
        chk("R6 code at gap", iid, 4'h2);
    endtask

    task automatic t_cancel();
        put(8'h44);
        take();
        ticks(3);
        chk("R7 held mid gap", thr_empty, 0);
        put(8'h55);
        take();
        ticks(8);
        chk("R7 restarted hold-back", thr_empty, 0);
        ticks(1);
        chk("R7 rises after full gap", thr_empty, 1);
    endtask

    task automatic t_zero_gap();
        stop_len = 8'd10;
        put(8'h66);
        take();
        chk("R6 zero gap immediate", thr_empty, 1);
        stop_len = 8'd1;
    endtask

    task automatic t_fill();
        for (int i = 0; i < 17; i++) put(8'hA0 + 8'(i));
        chk("R2 ready after fill", tx_ready, 1);
        for (int i = 0; i < 16; i++) begin
            chk("R2 order", tx_data, 8'hA0 + 8'(i));
            take();
        end
        chk("R2 overfill dropped", tx_ready, 0);
        chk("R5 immediate after fill", thr_empty, 1);
    endtask

    task automatic t_single_mode();
        put(8'h01); put(8'h02); put(8'h03);
        fifo_en = 1'b0;
        tick();
        chk("R8 flush ready", tx_ready, 0);
        chk("R8 flush flag", thr_empty, 1);
        put(8'h66);
        chk("R4 single write drops flag", thr_empty, 0);
        put(8'h77);
        chk("R3 keeps first byte", tx_data, 8'h66);
        take();
        chk("R3 no hold-back", thr_empty, 1);
        chk("R3 second write dropped", tx_ready, 0);
        chk("R9 no code in single mode", iid, 4'h1);
    endtask

    task automatic t_priority();
        fifo_en = 1'b1;
        tick();
        chk("R8 re-enable raises", iid, 4'h2);
        rx_tmo_pend = 1'b1; #1;
        chk("R11 timeout over tx", iid, 4'hC);
        rx_data_pend = 1'b1; #1;
        chk("R11 data over timeout", iid, 4'h4);
        iid_rd = 1'b1; tick(); iid_rd = 1'b0;
        rx_data_pend = 1'b0; rx_tmo_pend = 1'b0; #1;
        chk("R10 rx read keeps tx pending", iid, 4'h2);
        txe_ie = 1'b0; #1;
        chk("R9 disabled code", iid, 4'h1);
        chk("R9 disabled irq", irq, 0);
        txe_ie = 1'b1; #1;
        chk("R9 re-enabled code", iid, 4'h2);
        tick();
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_enable();
        t_pair_immediate();
        t_single_delay();
        t_cancel();
        t_zero_gap();
        t_fill();
        t_single_mode();
        t_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule